// File: doc/BRIEF.md
# HDLC Time-Slot Bit Router

This block sits between a framed T1 or E1 serial line and a bit-serial HDLC engine. It counts bit positions within each frame and marks, bit by bit, the positions that carry HDLC payload. On receive it copies each marked line bit to the HDLC side with a one-cycle valid strobe. On transmit it asks the HDLC engine for a bit ahead of each marked position and puts that bit in place of the line bit. Every other position passes through unchanged.

Four routing choices exist in each direction. The data-link route uses the T1 framing bit of alternate frames or the E1 spare bits Sa4 to Sa8 of frames without frame alignment. The single-slot route uses one time slot chosen by number. The multi-slot route uses a 32-bit enable map. The slot routes can also mask individual bits inside each octet, so HDLC can use a fraction of a 64 kbps channel. The receive side cannot be switched off. The transmit side can be disabled, and it then leaves the line untouched. Configuration is sampled at each frame boundary.

Top module: `hdlc_slot_router`

## Requirements
- R1: After reset, `rx_hdlc_valid`, `rx_hdlc_bit`, `tx_req` and `tx_line_out` are 0. Until the first strobe with `frame_start` high, no bit is routed in either direction and transmit passes the line bit through.
- R2: A strobe with `frame_start` high is position 0. A T1 frame is 193 positions: position 0 is the framing bit and positions 1..192 are slots 0..23. An E1 frame is 256 positions: slots 0..31, and slot s bit b is at position 8s+b. Bit b=0 is the first bit of a slot on the line. The T1/E1 choice and `dl_frame` are sampled at frame start.
- R3: Data-link route on T1 (`*_slot_mode`=0): only the framing bit is routed, and only in frames whose `dl_frame` was 1 at frame start.
- R4: Data-link route on E1: in frames with `dl_frame`=1 (frames without alignment signal), slot 0 bits b=3..7 are Sa4..Sa8. `sa_sel[4]` enables Sa4 and `sa_sel[0]` enables Sa8. No other bit is routed.
- R5: Single-slot route (`slot_mode`=1, `multi`=0): only slot `slot_num` (0..31) is routed. On T1 a number of 24 or more routes nothing.
- R6: Multi-slot route (`slot_mode`=1, `multi`=1): slot k is routed when `chan_map[k]` is 1 (k=0 is channel 1). On T1, map bits 24..31 have no effect.
- R7: In the slot routes, bit b of a routed slot is dropped when `supp[7-b]` is 1. A mask bit of 0 keeps the bit.
- R8: Receive: each routed position gives exactly one `rx_hdlc_valid` pulse in the cycle after its strobe, with `rx_hdlc_bit` equal to the line bit, in line order.
- R9: Transmit: `tx_req` is high in the cycle after the strobe of a routed position. `tx_line_out` changes one cycle later, to the `tx_hdlc_bit` held during the request cycle, or to that position's `tx_line_in` if the position is not routed.
- R10: With `tx_enable`=0, or with a multi-slot map of all zeros, no `tx_req` is raised and `tx_line_out` equals the line input.
- R11: Changes to the configuration inputs in mid-frame have no effect until the next frame start strobe.
- R12: Receive routing has no enable and works regardless of the transmit settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | One-cycle bit strobe; strobes at least 2 cycles apart |
| frame_start | input | 1 | Marks the strobe of frame position 0 |
| t1_mode | input | 1 | 1 = T1 framing, 0 = E1 (sampled at frame start) |
| dl_frame | input | 1 | Frame carries data link (T1 FDL frame / E1 non-alignment frame) |
| rx_line | input | 1 | Receive line bit |
| rx_slot_mode | input | 1 | Receive: 0 data link, 1 time slots |
| rx_multi | input | 1 | Receive: 1 map, 0 single slot |
| rx_slot_num | input | 5 | Receive single slot number |
| rx_chan_map | input | 32 | Receive slot enable map |
| rx_supp | input | 8 | Receive bit suppression mask |
| rx_sa_sel | input | 5 | Receive Sa4..Sa8 enables |
| rx_hdlc_bit | output | 1 | Extracted HDLC bit |
| rx_hdlc_valid | output | 1 | Extracted bit valid |
| tx_enable | input | 1 | Transmit routing enable |
| tx_slot_mode | input | 1 | Transmit: 0 data link, 1 time slots |
| tx_multi | input | 1 | Transmit: 1 map, 0 single slot |
| tx_slot_num | input | 5 | Transmit single slot number |
| tx_chan_map | input | 32 | Transmit slot enable map |
| tx_supp | input | 8 | Transmit bit suppression mask |
| tx_sa_sel | input | 5 | Transmit Sa4..Sa8 enables |
| tx_line_in | input | 1 | Transmit line bit before insertion |
| tx_hdlc_bit | input | 1 | HDLC bit supplied during a request |
| tx_req | output | 1 | Request for an HDLC bit |
| tx_line_out | output | 1 | Transmit line bit after insertion |

## Verification
The in-RTL properties check the timing shape on every cycle. The position counter stays inside the current frame length. T1 payload never decodes to a slot above 23. Receive valids and transmit requests only appear the cycle after a strobe. The transmit output only moves on its update cycle, and no request is raised while transmit is off. Which positions are routed is a question of content: Sa mapping order, mask polarity, ignored T1 map bits, and a configuration change held off until the frame boundary. Only the bench scenarios can show these, by comparing every routed bit against an expected queue.

// File: rtl/hsr_pkg.sv
package hsr_pkg;
   localparam int unsigned SLOT_BITS  = 8;
   localparam int unsigned MAX_SLOTS  = 32;
   localparam int unsigned T1_SLOTS   = 24;
   localparam int unsigned SA_COUNT   = 5;
   localparam int unsigned SA_FIRST   = 3;
   localparam int unsigned BIT_W      = $clog2(SLOT_BITS);
   localparam int unsigned SLOT_W     = $clog2(MAX_SLOTS);
   localparam int unsigned E1_LEN     = MAX_SLOTS * SLOT_BITS;
   localparam int unsigned T1_LEN     = T1_SLOTS * SLOT_BITS + 1;
   localparam int unsigned MAX_LEN    = (E1_LEN > T1_LEN) ? E1_LEN : T1_LEN;
   localparam int unsigned POS_W      = $clog2(MAX_LEN);

   typedef struct packed {
      logic                 slot_mode;
      logic                 multi;
      logic [SLOT_W-1:0]    slot_num;
      logic [MAX_SLOTS-1:0] chan_map;
      logic [SLOT_BITS-1:0] supp;
      logic [SA_COUNT-1:0]  sa_sel;
   } route_cfg_t;

   typedef struct packed {
      logic              valid;
      logic              fbit;
      logic [SLOT_W-1:0] slot;
      logic [BIT_W-1:0]  bitn;
      logic              t1;
      logic              dl;
   } pos_info_t;
endpackage

// File: rtl/hsr_cfg_shadow.sv
module hsr_cfg_shadow #(
   parameter int unsigned W = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] d_in,
   output logic [W-1:0] eff
);
   logic [W-1:0] q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= d_in;
   end

   // the loading strobe already sees the new setting
   assign eff = load ? d_in : q;
endmodule

// File: rtl/hsr_frame_counter.sv
module hsr_frame_counter
   import hsr_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      bit_en,
   input  logic      frame_start,
   input  logic      t1_mode,
   input  logic      dl_frame,
   output pos_info_t cur
);
   localparam logic [POS_W-1:0] T1_LAST = POS_W'(T1_LEN - 1);
   localparam logic [POS_W-1:0] E1_LAST = POS_W'(E1_LEN - 1);

   logic             fs;
   logic [1:0]       mode_eff;
   logic [POS_W-1:0] pos_q, pos, last, off;
   logic             synced_q;

   assign fs = bit_en & frame_start;

   hsr_cfg_shadow #(.W(2)) u_mode (
      .clk(clk), .rst_n(rst_n), .load(fs),
      .d_in({t1_mode, dl_frame}), .eff(mode_eff)
   );

   assign pos  = fs ? '0 : pos_q;
   assign last = mode_eff[1] ? T1_LAST : E1_LAST;
   assign off  = mode_eff[1] ? pos - 1'b1 : pos;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q    <= '0;
         synced_q <= 1'b0;
      end else if (bit_en) begin
         pos_q    <= (pos == last) ? '0 : pos + 1'b1;
         synced_q <= synced_q | fs;
      end
   end

   always_comb begin
      cur.valid = bit_en & (synced_q | fs);
      cur.fbit  = mode_eff[1] & (pos == '0);
      cur.slot  = off[POS_W-1:BIT_W];
      cur.bitn  = off[BIT_W-1:0];
      cur.t1    = mode_eff[1];
      cur.dl    = mode_eff[0];
   end

   a_r2_pos_bound: assert property (@(posedge clk) disable iff (!rst_n)
      bit_en |=> (pos_q <= $past(last)));

   a_r6_t1_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
      (cur.valid && cur.t1 && !cur.fbit) |-> (cur.slot < SLOT_W'(T1_SLOTS)));
endmodule

// File: rtl/hsr_slot_select.sv
module hsr_slot_select
   import hsr_pkg::*;
#(
   parameter bit IS_TX = 1'b0
) (
   input  pos_info_t  cur,
   input  route_cfg_t cfg,
   input  logic       dir_on,
   output logic       sel
);
   localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(SLOT_BITS - 1);

   logic                 gate;
   logic                 link_hit, slot_hit, slot_exists, slot_pick;
   logic [SLOT_BITS-1:0] sa_ext;
   logic [BIT_W-1:0]     rev_idx;

   generate
      if (IS_TX) begin : g_tx_gate
         assign gate = dir_on;
      end else begin : g_rx_gate
         // receive routing cannot be turned off
         assign gate = 1'b1;
      end
   endgenerate

   // the mask and Sa fields number bits from the last line bit upward
   assign rev_idx = TOP_BIT - cur.bitn;
   assign sa_ext  = SLOT_BITS'(cfg.sa_sel);

   always_comb begin
      if (cur.t1)
         link_hit = cur.fbit & cur.dl;
      else
         link_hit = cur.dl & (cur.slot == '0) & sa_ext[rev_idx];

      slot_exists = cur.t1 ? (cur.slot < SLOT_W'(T1_SLOTS)) : 1'b1;
      slot_pick   = cfg.multi ? cfg.chan_map[cur.slot] : (cur.slot == cfg.slot_num);
      slot_hit    = ~cur.fbit & slot_exists & slot_pick & ~cfg.supp[rev_idx];

      sel = cur.valid & gate & (cfg.slot_mode ? slot_hit : link_hit);
   end
endmodule

// File: rtl/hsr_rx_tap.sv
module hsr_rx_tap (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe,
   input  logic sel,
   input  logic line,
   output logic hdlc_bit,
   output logic hdlc_valid
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hdlc_bit   <= 1'b0;
         hdlc_valid <= 1'b0;
      end else begin
         hdlc_valid <= sel;
         if (sel) hdlc_bit <= line;
      end
   end

   a_r8_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      hdlc_valid |-> $past(strobe));
endmodule

// File: rtl/hsr_tx_insert.sv
module hsr_tx_insert (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe,
   input  logic sel,
   input  logic line_in,
   input  logic hdlc_bit,
   output logic req,
   output logic line_out
);
   logic held_q, pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req      <= 1'b0;
         held_q   <= 1'b0;
         pend_q   <= 1'b0;
         line_out <= 1'b0;
      end else begin
         req    <= strobe & sel;
         pend_q <= strobe;
         if (strobe) held_q <= line_in;
         if (pend_q) line_out <= req ? hdlc_bit : held_q;
      end
   end

   a_r9_req_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      req |-> $past(strobe));

   a_r9_out_moves_on_update: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(line_out) |-> $past(pend_q));
endmodule

// File: rtl/hdlc_slot_router.sv
module hdlc_slot_router
   import hsr_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bit_en,
   input  logic                 frame_start,
   input  logic                 t1_mode,
   input  logic                 dl_frame,
   input  logic                 rx_line,
   input  logic                 rx_slot_mode,
   input  logic                 rx_multi,
   input  logic [SLOT_W-1:0]    rx_slot_num,
   input  logic [MAX_SLOTS-1:0] rx_chan_map,
   input  logic [SLOT_BITS-1:0] rx_supp,
   input  logic [SA_COUNT-1:0]  rx_sa_sel,
   output logic                 rx_hdlc_bit,
   output logic                 rx_hdlc_valid,
   input  logic                 tx_enable,
   input  logic                 tx_slot_mode,
   input  logic                 tx_multi,
   input  logic [SLOT_W-1:0]    tx_slot_num,
   input  logic [MAX_SLOTS-1:0] tx_chan_map,
   input  logic [SLOT_BITS-1:0] tx_supp,
   input  logic [SA_COUNT-1:0]  tx_sa_sel,
   input  logic                 tx_line_in,
   input  logic                 tx_hdlc_bit,
   output logic                 tx_req,
   output logic                 tx_line_out
);
   localparam int unsigned CFG_W = $bits(route_cfg_t);

   generate
      if (SA_FIRST + SA_COUNT != SLOT_BITS) begin : g_bad_sa
         $error("spare bits must end at the last bit of slot 0");
      end
      if (POS_W - BIT_W != SLOT_W) begin : g_bad_pos
         $error("position width must split into slot and bit fields");
      end
      if (T1_SLOTS > MAX_SLOTS) begin : g_bad_t1
         $error("T1 slot count exceeds frame slot count");
      end
   endgenerate

   pos_info_t  cur;
   route_cfg_t rx_cfg_in, tx_cfg_in, rx_cfg, tx_cfg;
   logic       fs, tx_on, rx_sel, tx_sel;

   assign fs = bit_en & frame_start;

   assign rx_cfg_in = '{slot_mode: rx_slot_mode, multi: rx_multi, slot_num: rx_slot_num,
                        chan_map: rx_chan_map, supp: rx_supp, sa_sel: rx_sa_sel};
   assign tx_cfg_in = '{slot_mode: tx_slot_mode, multi: tx_multi, slot_num: tx_slot_num,
                        chan_map: tx_chan_map, supp: tx_supp, sa_sel: tx_sa_sel};

   hsr_frame_counter u_cnt (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_start(frame_start),
      .t1_mode(t1_mode), .dl_frame(dl_frame), .cur(cur)
   );

   hsr_cfg_shadow #(.W(CFG_W)) u_rx_shadow (
      .clk(clk), .rst_n(rst_n), .load(fs), .d_in(rx_cfg_in), .eff(rx_cfg)
   );

   hsr_cfg_shadow #(.W(CFG_W + 1)) u_tx_shadow (
      .clk(clk), .rst_n(rst_n), .load(fs),
      .d_in({tx_enable, tx_cfg_in}), .eff({tx_on, tx_cfg})
   );

   hsr_slot_select #(.IS_TX(1'b0)) u_rx_sel (
      .cur(cur), .cfg(rx_cfg), .dir_on(1'b1), .sel(rx_sel)
   );

   hsr_slot_select #(.IS_TX(1'b1)) u_tx_sel (
      .cur(cur), .cfg(tx_cfg), .dir_on(tx_on), .sel(tx_sel)
   );

   hsr_rx_tap u_rx (
      .clk(clk), .rst_n(rst_n), .strobe(bit_en), .sel(rx_sel), .line(rx_line),
      .hdlc_bit(rx_hdlc_bit), .hdlc_valid(rx_hdlc_valid)
   );

   hsr_tx_insert u_tx (
      .clk(clk), .rst_n(rst_n), .strobe(bit_en), .sel(tx_sel), .line_in(tx_line_in),
      .hdlc_bit(tx_hdlc_bit), .req(tx_req), .line_out(tx_line_out)
   );

   a_r10_off_no_req: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && !tx_on) |=> !tx_req);

   a_r1_no_route_unsynced: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && !cur.valid) |=> (!tx_req && !rx_hdlc_valid));
endmodule

// File: tb/hdlc_slot_router_test.sv
`timescale 1ns/1ps
module hdlc_slot_router_test;
   typedef struct packed {
      bit        en;
      bit        sm;
      bit        mu;
      bit [4:0]  num;
      bit [31:0] map;
      bit [7:0]  supp;
      bit [4:0]  sa;
   } cfg_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_en = 0, frame_start = 0, t1_mode = 0, dl_frame = 0;
   logic rx_line = 0, tx_line_in = 0, tx_hdlc_bit = 0;
   logic rx_hdlc_bit, rx_hdlc_valid, tx_req, tx_line_out;
   cfg_t rcfg = '0, tcfg = '0, rnext = '0, tnext = '0;
   bit   rxq[$];
   int   checks = 0, fails = 0;
   string cur_tag = "R8";
   bit [15:0] lfsr = 16'hACE1;

   always #4 clk = ~clk;

   hdlc_slot_router uut (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_start(frame_start),
      .t1_mode(t1_mode), .dl_frame(dl_frame), .rx_line(rx_line),
      .rx_slot_mode(rcfg.sm), .rx_multi(rcfg.mu), .rx_slot_num(rcfg.num),
      .rx_chan_map(rcfg.map), .rx_supp(rcfg.supp), .rx_sa_sel(rcfg.sa),
      .rx_hdlc_bit(rx_hdlc_bit), .rx_hdlc_valid(rx_hdlc_valid),
      .tx_enable(tcfg.en), .tx_slot_mode(tcfg.sm), .tx_multi(tcfg.mu),
      .tx_slot_num(tcfg.num), .tx_chan_map(tcfg.map), .tx_supp(tcfg.supp),
      .tx_sa_sel(tcfg.sa), .tx_line_in(tx_line_in), .tx_hdlc_bit(tx_hdlc_bit),
      .tx_req(tx_req), .tx_line_out(tx_line_out)
   );

   function automatic bit rnd();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      return lfsr[0];
   endfunction

   task automatic chk(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // expected routing from the requirement text
   function automatic bit routed(bit t1, int pos, bit dl, cfg_t c);
      int off, slot, b;
      if (t1 && pos == 0) return !c.sm && dl;
      off  = t1 ? pos - 1 : pos;
      slot = off / 8;
      b    = off % 8;
      if (!c.sm) begin
         if (t1 || !dl || slot != 0 || b < 3) return 0;
         return c.sa[7 - b];
      end
      if (t1 && slot >= 24) return 0;
      if (c.mu ? !c.map[slot] : (slot != c.num)) return 0;
      return !c.supp[7 - b];
   endfunction

   // one line bit: strobe, request check, output check
   task automatic step(bit fs, bit ers, bit ets, string tag);
      bit rl, tl, hb;
      @(negedge clk);
      rl = rnd(); tl = rnd();
      bit_en = 1; frame_start = fs; rx_line = rl; tx_line_in = tl;
      if (ers) rxq.push_back(rl);
      @(negedge clk);
      bit_en = 0; frame_start = 0;
      chk(tx_req == ets, {tag, " R9 tx_req"}, tx_req, ets);
      hb = rnd();
      tx_hdlc_bit = hb;
      @(negedge clk);
      chk(tx_line_out == (ets ? hb : tl), {tag, " R9 tx_line_out"}, tx_line_out, ets ? hb : tl);
   endtask

   task automatic run_frame(bit t1, bit dl, int chg_at, string tag);
      cfg_t rs, ts;
      int len;
      rs = rcfg; ts = tcfg;
      t1_mode = t1; dl_frame = dl;
      len = t1 ? 193 : 256;
      cur_tag = tag;
      for (int p = 0; p < len; p++) begin
         if (p == chg_at) begin
            rcfg = rnext; tcfg = tnext;
            t1_mode = !t1; dl_frame = !dl;
         end
         step(p == 0, routed(t1, p, dl, rs), ts.en && routed(t1, p, dl, ts), tag);
      end
   endtask

   task automatic drain(string tag);
      repeat (4) @(negedge clk);
      chk(rxq.size() == 0, {tag, " R8 receive queue empty"}, rxq.size(), 0);
      rxq.delete();
   endtask

   // monitor: each receive valid pops one expected bit
   always @(negedge clk) begin
      if (rst_n && rx_hdlc_valid) begin
         if (rxq.size() == 0) begin
            chk(0, {cur_tag, " R8 unexpected rx valid"}, 1, 0);
         end else begin
            bit e;
            e = rxq.pop_front();
            chk(rx_hdlc_bit == e, {cur_tag, " R8 rx bit"}, rx_hdlc_bit, e);
         end
      end
   end

   initial begin
      #(8ns * 200000);
      chk(0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(rx_hdlc_valid == 0, "R1 rx_valid", rx_hdlc_valid, 0);
      chk(rx_hdlc_bit == 0, "R1 rx_bit", rx_hdlc_bit, 0);
      chk(tx_req == 0, "R1 tx_req", tx_req, 0);
      chk(tx_line_out == 0, "R1 tx_line_out", tx_line_out, 0);
      // R1 strobes before any frame start route nothing
      rcfg = '{en:1, sm:1, mu:1, num:0, map:32'hFFFF_FFFF, supp:0, sa:0};
      tcfg = rcfg;
      cur_tag = "R1";
      for (int i = 0; i < 20; i++) step(0, 0, 0, "R1");
      drain("R1");

      // R3 T1 data link, with and without the link frame flag
      rcfg = '{en:1, sm:0, mu:0, num:0, map:0, supp:0, sa:5'h1F};
      tcfg = rcfg;
      run_frame(1, 1, -1, "R3");
      run_frame(1, 0, -1, "R3");
      run_frame(1, 1, -1, "R3");
      drain("R3");

      // R4 E1 spare bits, partial selection, alignment frame skipped
      rcfg = '{en:1, sm:0, mu:0, num:0, map:0, supp:0, sa:5'b10110};
      tcfg = '{en:1, sm:0, mu:0, num:0, map:0, supp:0, sa:5'b01001};
      run_frame(0, 1, -1, "R4");
      run_frame(0, 0, -1, "R4");
      drain("R4");

      // R5 / R7 E1 single slot 31 with edge bits masked
      rcfg = '{en:1, sm:1, mu:0, num:31, map:0, supp:8'h81, sa:0};
      tcfg = '{en:1, sm:1, mu:0, num:0, map:0, supp:8'h3C, sa:0};
      run_frame(0, 0, -1, "R7");
      drain("R7");

      // R5 T1 last slot, then a slot number beyond T1
      rcfg = '{en:1, sm:1, mu:0, num:23, map:0, supp:0, sa:0};
      tcfg = '{en:1, sm:1, mu:0, num:27, map:0, supp:0, sa:0};
      run_frame(1, 1, -1, "R5");
      drain("R5");

      // R6 T1 map with high bits that must be ignored
      rcfg = '{en:1, sm:1, mu:1, num:0, map:32'hFF80_0105, supp:8'h10, sa:0};
      tcfg = '{en:1, sm:1, mu:1, num:0, map:32'hFF00_0001, supp:0, sa:0};
      run_frame(1, 0, -1, "R6");
      drain("R6");

      // R6 E1 map including slot 31 and slot 0
      rcfg = '{en:1, sm:1, mu:1, num:0, map:32'h8000_0011, supp:0, sa:0};
      tcfg = '{en:1, sm:1, mu:1, num:0, map:32'h4000_8001, supp:8'hF0, sa:0};
      run_frame(0, 1, -1, "R6");
      drain("R6");

      // R10 / R12 transmit off and zero map; receive keeps routing
      rcfg = '{en:0, sm:1, mu:1, num:0, map:32'h0000_0F00, supp:0, sa:0};
      tcfg = '{en:0, sm:1, mu:1, num:0, map:32'hFFFF_FFFF, supp:0, sa:0};
      run_frame(0, 0, -1, "R10");
      drain("R12");
      tcfg = '{en:1, sm:1, mu:1, num:0, map:32'h0, supp:0, sa:0};
      run_frame(1, 0, -1, "R10");
      drain("R10");

      // R11 mid-frame change waits for the next frame start
      rcfg  = '{en:1, sm:1, mu:0, num:20, map:0, supp:0, sa:0};
      tcfg  = '{en:1, sm:1, mu:1, num:0, map:32'h0010_0000, supp:0, sa:0};
      rnext = '{en:1, sm:1, mu:0, num:2, map:0, supp:0, sa:0};
      tnext = '{en:1, sm:1, mu:1, num:0, map:32'h0000_0004, supp:0, sa:0};
      run_frame(0, 0, 30, "R11");
      run_frame(0, 0, -1, "R11");
      drain("R11");

      // R2 switch back to T1 framing and count its length again
      rcfg = '{en:1, sm:1, mu:0, num:0, map:0, supp:0, sa:0};
      tcfg = '{en:1, sm:1, mu:0, num:23, map:0, supp:0, sa:0};
      run_frame(1, 0, -1, "R2");
      run_frame(1, 0, -1, "R2");
      drain("R2");

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule